// File: doc/BRIEF.md
# Flag Offset Register Loader

This block keeps the two threshold offsets that a FIFO's flag logic compares its fill level against: one for the almost-empty flag and one for the almost-full flag. Both offsets sit in registers on the write clock and drive the comparators directly through two output buses.

A master reset loads both offsets with one of eight preset thresholds. The preset is chosen by a 3-bit code built from the load pin and two select pins, and the code is sampled while the master reset is held. After that, software or board logic can rewrite the offsets in two ways. The first is a parallel write from the low bits of the write data bus. It uses a load strobe together with write enable, and successive writes alternate between the two offsets. The second is a serial stream on a dedicated serial clock gated by a serial enable. The stream is assembled in the serial clock domain and moved into the write clock domain as a complete frame. A partial reset keeps both offsets as they are.

Top module: `flag_ofs_loader`

## Requirements
- R1: While rst_ni is low, both offsets read 7 and the next parallel write is aimed at the almost-empty offset.
- R2: At a rising clk_i edge with mrs_i high, both offsets become 2^(c+3)-1. Here c = {ld_i, fsel_i[1], fsel_i[0]} (ld_i is the MSB) sampled at that edge, which gives 7, 15, 31, 63, 127, 255, 511 or 1023. The parallel sequence restarts at the almost-empty offset.
- R3: At a rising clk_i edge with ld_i and wen_i both high and no reset active, din_i is written to one offset. The first write after any reset goes to the almost-empty offset, and later writes alternate between almost-full and almost-empty.
- R4: ld_i high with wen_i low, or wen_i high with ld_i low, changes neither offset nor the parallel sequence.
- R5: An edge with prs_i high leaves both offsets unchanged and ignores any parallel write in that cycle. It restarts the parallel sequence at the almost-empty offset.
- R6: Each rising sclk_i edge with sen_i high shifts in one bit of sdi_i. Frame bits 0 to OFS_W-1 are the almost-empty offset, least significant bit first. Bits OFS_W to 2*OFS_W-1 are the almost-full offset, least significant bit first. Both offsets take the frame together by the third rising clk_i edge after the last serial bit.
- R7: sclk_i edges with sen_i low shift nothing. An incomplete serial frame leaves both offsets unchanged.
- R8: A serial frame does not move the parallel sequence. Priority is master reset, then serial frame, then parallel write; a parallel write that coincides with a serial frame is dropped.
- R9: The offsets change only through R2, R3 or R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock; offset registers live here |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| mrs_i | input | 1 | Synchronous master reset, loads presets |
| prs_i | input | 1 | Synchronous partial reset, offsets kept |
| fsel_i | input | 2 | Preset select, low two code bits |
| ld_i | input | 1 | Load strobe; preset code MSB during mrs_i |
| wen_i | input | 1 | Write enable qualifying a parallel load |
| din_i | input | OFS_W | Parallel offset value |
| sclk_i | input | 1 | Dedicated serial programming clock |
| sen_i | input | 1 | Serial enable |
| sdi_i | input | 1 | Serial data in |
| ae_ofs_o | output | OFS_W | Almost-empty offset |
| af_ofs_o | output | OFS_W | Almost-full offset |

## Verification
The assertions check the following rules on every write-clock edge:
- the preset that follows a master reset;
- the target and value of each parallel write;
- holding of the offsets during partial reset and idle cycles;
- the atomic copy of a finished serial frame.

On the serial clock they check that the bit counter stays within the frame. Other properties can only be shown by the bench's scenarios, because they depend on what was shifted in over several serial clock edges. These are the bit order of a serial frame, dropping of bits shifted with sen_i low, and that a half-finished frame has no effect. The same applies to keeping the alternation order across serial frames and partial resets, since that depends on the history of earlier writes.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic {
    SLOT_AE = 1'b0,
    SLOT_AF = 1'b1
  } slot_e;

  // 2^(code+3)-1 : 7 .. 1023
  function automatic logic [31:0] preset_val(input logic [SEL_W-1:0] code);
    preset_val = (32'd1 << (32'(code) + 32'd3)) - 32'd1;
  endfunction
endpackage

// File: rtl/ofs_serial_shift.sv
module ofs_serial_shift #(
  parameter int unsigned OFS_W = 10,
  localparam int unsigned FRAME_W = 2 * OFS_W,
  localparam int unsigned CNT_W = $clog2(FRAME_W)
) (
  input  logic               sclk_i,
  input  logic               rst_ni,
  input  logic               sen_i,
  input  logic               sdi_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               done_tgl_o,
  output logic [CNT_W-1:0]   bit_cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q;

  // shift right: first bit ends in position 0
  assign sh_d = {sdi_i, sh_q[FRAME_W-1:1]};

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      frame_o    <= '0;
      done_tgl_o <= 1'b0;
    end else if (sen_i) begin
      sh_q <= sh_d;
      if (cnt_q == LAST) begin
        cnt_q      <= '0;
        frame_o    <= sh_d;
        done_tgl_o <= ~done_tgl_o;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/ofs_tgl_sync.sv
module ofs_tgl_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tgl_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pulse_o = s2_q ^ s3_q;
endmodule

// File: rtl/ofs_par_seq.sv
module ofs_par_seq
  import flag_ofs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rearm_i,
  input  logic  adv_i,
  output slot_e slot_o
);
  slot_e slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot_q <= SLOT_AE;
    else if (rearm_i) slot_q <= SLOT_AE;
    else if (adv_i)   slot_q <= (slot_q == SLOT_AE) ? SLOT_AF : SLOT_AE;
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader
  import flag_ofs_pkg::*;
#(
  parameter int unsigned OFS_W = 10,
  localparam int unsigned FRAME_W = 2 * OFS_W,
  localparam int unsigned CNT_W = $clog2(FRAME_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mrs_i,
  input  logic             prs_i,
  input  logic [1:0]       fsel_i,
  input  logic             ld_i,
  input  logic             wen_i,
  input  logic [OFS_W-1:0] din_i,
  input  logic             sclk_i,
  input  logic             sen_i,
  input  logic             sdi_i,
  output logic [OFS_W-1:0] ae_ofs_o,
  output logic [OFS_W-1:0] af_ofs_o
);
  localparam logic [OFS_W-1:0] RST_OFS = OFS_W'(7);

  logic [FRAME_W-1:0] frame_w;
  logic               done_tgl_w;
  logic [CNT_W-1:0]   bit_cnt_w;
  logic               xfer_w;
  logic               par_wr_w;
  slot_e              slot_w;
  logic [SEL_W-1:0]   code_w;
  logic [OFS_W-1:0]   preset_w;
  logic [OFS_W-1:0]   ofs_q [2];

  assign code_w   = {ld_i, fsel_i};
  assign preset_w = OFS_W'(preset_val(code_w));
  assign par_wr_w = ld_i & wen_i & ~mrs_i & ~prs_i & ~xfer_w;

  ofs_serial_shift #(.OFS_W(OFS_W)) u_ser (
    .sclk_i    (sclk_i),
    .rst_ni    (rst_ni),
    .sen_i     (sen_i),
    .sdi_i     (sdi_i),
    .frame_o   (frame_w),
    .done_tgl_o(done_tgl_w),
    .bit_cnt_o (bit_cnt_w)
  );

  ofs_tgl_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tgl_i  (done_tgl_w),
    .pulse_o(xfer_w)
  );

  ofs_par_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rearm_i(mrs_i | prs_i),
    .adv_i  (par_wr_w),
    .slot_o (slot_w)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ofs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ofs_q[g] <= RST_OFS;
      else if (mrs_i)                          ofs_q[g] <= preset_w;
      else if (xfer_w)                         ofs_q[g] <= frame_w[g*OFS_W +: OFS_W];
      else if (par_wr_w && slot_w == slot_e'(g)) ofs_q[g] <= din_i;
    end
  end

  assign ae_ofs_o = ofs_q[0];
  assign af_ofs_o = ofs_q[1];
endmodule

// File: rtl/flag_ofs_loader_chk.sv
module flag_ofs_loader_chk
  import flag_ofs_pkg::*;
#(
  parameter int unsigned OFS_W = 10,
  localparam int unsigned FRAME_W = 2 * OFS_W,
  localparam int unsigned CNT_W = $clog2(FRAME_W)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mrs_i,
  input logic               prs_i,
  input logic [1:0]         fsel_i,
  input logic               ld_i,
  input logic               wen_i,
  input logic [OFS_W-1:0]   din_i,
  input logic               sclk_i,
  input logic [OFS_W-1:0]   ae_ofs_o,
  input logic [OFS_W-1:0]   af_ofs_o,
  input logic               xfer_i,
  input slot_e              slot_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic [CNT_W-1:0]   bit_cnt_i
);
  logic [OFS_W-1:0] exp_preset;
  logic             wr_req;
  assign exp_preset = OFS_W'(preset_val({ld_i, fsel_i}));
  assign wr_req     = ld_i & wen_i;

  assert_preset_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_i |=> (ae_ofs_o == $past(exp_preset)) && (af_ofs_o == $past(exp_preset)));

  assert_par_ae_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mrs_i && !prs_i && !xfer_i && wr_req && slot_i == SLOT_AE)
      |=> (ae_ofs_o == $past(din_i)) && $stable(af_ofs_o));

  assert_par_af_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mrs_i && !prs_i && !xfer_i && wr_req && slot_i == SLOT_AF)
      |=> (af_ofs_o == $past(din_i)) && $stable(ae_ofs_o));

  assert_prs_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prs_i && !mrs_i && !xfer_i) |=> $stable(ae_ofs_o) && $stable(af_ofs_o));

  assert_frame_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !mrs_i) |=> ({af_ofs_o, ae_ofs_o} == $past(frame_i)));

  assert_bit_cnt_R7: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    int'(bit_cnt_i) < FRAME_W);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mrs_i && !wr_req && !xfer_i) |=> $stable(ae_ofs_o) && $stable(af_ofs_o));
endmodule

bind flag_ofs_loader flag_ofs_loader_chk #(.OFS_W(OFS_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mrs_i    (mrs_i),
  .prs_i    (prs_i),
  .fsel_i   (fsel_i),
  .ld_i     (ld_i),
  .wen_i    (wen_i),
  .din_i    (din_i),
  .sclk_i   (sclk_i),
  .ae_ofs_o (ae_ofs_o),
  .af_ofs_o (af_ofs_o),
  .xfer_i   (xfer_w),
  .slot_i   (slot_w),
  .frame_i  (frame_w),
  .bit_cnt_i(bit_cnt_w)
);

// File: tb/tb_flag_ofs_loader.sv
`timescale 1ns/1ps
module tb_flag_ofs_loader;
  localparam int unsigned OFS_W = 10;

  logic clk = 1'b0, rst_ni = 1'b0, mrs = 1'b0, prs = 1'b0;
  logic [1:0] fsel = '0;
  logic ld = 1'b0, wen = 1'b0, sclk = 1'b0, sen = 1'b0, sdi = 1'b0;
  logic [OFS_W-1:0] din = '0;
  logic [OFS_W-1:0] ae, af;

  int n_chk = 0, n_bad = 0;
  logic [OFS_W-1:0] m_ae, m_af;
  bit m_slot;

  always #2.5 clk = ~clk;

  flag_ofs_loader #(.OFS_W(OFS_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mrs_i(mrs), .prs_i(prs), .fsel_i(fsel),
    .ld_i(ld), .wen_i(wen), .din_i(din), .sclk_i(sclk), .sen_i(sen),
    .sdi_i(sdi), .ae_ofs_o(ae), .af_ofs_o(af)
  );

  function automatic logic [OFS_W-1:0] preset_of(input int c);
    return OFS_W'((1 << (c + 3)) - 1);
  endfunction

  task automatic chk(input string req, input logic [OFS_W-1:0] act, input logic [OFS_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_both(input string req);
    chk({req, " ae"}, ae, m_ae);
    chk({req, " af"}, af, m_af);
  endtask

  task automatic do_mrs(input int c);
    @(negedge clk); mrs = 1'b1; ld = c[2]; fsel = c[1:0]; wen = 1'b0;
    @(negedge clk); mrs = 1'b0; ld = 1'b0;
    m_ae = preset_of(c); m_af = m_ae; m_slot = 1'b0;
    chk_both("R2 preset");
  endtask

  task automatic do_par(input logic [OFS_W-1:0] d);
    @(negedge clk); ld = 1'b1; wen = 1'b1; din = d;
    @(negedge clk); ld = 1'b0; wen = 1'b0;
    if (!m_slot) m_ae = d; else m_af = d;
    m_slot = ~m_slot;
    chk_both("R3 parallel");
  endtask

  task automatic do_half_strobe(input logic [OFS_W-1:0] d, input bit use_ld);
    @(negedge clk); ld = use_ld; wen = ~use_ld; din = d;
    @(negedge clk); ld = 1'b0; wen = 1'b0;
    chk_both("R4 lone strobe");
  endtask

  task automatic do_prs(input logic [OFS_W-1:0] d);
    @(negedge clk); prs = 1'b1; ld = 1'b1; wen = 1'b1; din = d;
    @(negedge clk); prs = 1'b0; ld = 1'b0; wen = 1'b0;
    m_slot = 1'b0;
    chk_both("R5 partial reset");
  endtask

  task automatic sbit(input bit b, input bit en);
    sdi = b; sen = en;
    #3 sclk = 1'b1;
    #7 sclk = 1'b0;
    #4;
  endtask

  // R6/R7: full frame, optional ignored bits, optional abort midway
  task automatic do_serial(input logic [OFS_W-1:0] a, input logic [OFS_W-1:0] f, input bit gaps);
    for (int i = 0; i < 2*OFS_W; i++) begin
      if (gaps && ($urandom_range(0, 3) == 0)) sbit(1'($urandom), 1'b0);
      sbit((i < OFS_W) ? a[i] : f[i-OFS_W], 1'b1);
      if (i == OFS_W - 1) begin
        repeat (5) @(negedge clk);
        chk_both("R7 partial frame");
      end
    end
    sen = 1'b0;
    repeat (5) @(negedge clk);
    m_ae = a; m_af = f;
    chk_both("R6 serial frame");
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    m_ae = 7; m_af = 7; m_slot = 1'b0;
    #12;
    chk_both("R1 reset");
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk_both("R1 after release");
    // R1: first write after reset targets almost-empty
    do_par(10'd100);
    do_par(10'd200);
    // R2: every preset code, boundaries 7 and 1023
    for (int c = 0; c < 8; c++) do_mrs(c);
    do_par(10'd3);
    // R4: lone strobes, sequence must still be on almost-full
    do_half_strobe(10'h155, 1'b1);
    do_half_strobe(10'h2AA, 1'b0);
    do_par(10'd999);
    // R5: rearm mid-sequence
    do_par(10'd11);
    do_prs(10'd55);
    do_par(10'd22);
    // R8: serial does not move sequence
    do_serial(10'h3FF, 10'h000, 1'b0);
    do_par(10'd44);
    do_serial(10'h001, 10'h200, 1'b1);
    // R9 idle
    repeat (4) @(negedge clk);
    chk_both("R9 idle");
    for (int it = 0; it < 60; it++) begin
      case ($urandom_range(0, 5))
        0: do_mrs($urandom_range(0, 7));
        1, 2: do_par(OFS_W'($urandom));
        3: do_half_strobe(OFS_W'($urandom), 1'($urandom));
        4: do_prs(OFS_W'($urandom));
        default: do_serial(OFS_W'($urandom), OFS_W'($urandom), 1'($urandom));
      endcase
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule